// File: doc/BRIEF.md
# Move-Wide Immediate Execution Unit

This unit executes the move-wide-immediate group of a 64-bit instruction set. It takes an already fetched 32-bit instruction word with a valid strobe. It also takes the current contents of the destination register, which arrive from a register-file read port. From these it produces a registered write-back: a write enable, the destination index, the 64-bit result and a flag that marks a 32-bit register form.

A 16-bit immediate is placed into one of four halfword lanes of the result. There are three operations:

- **Inverted form:** writes the complement of the placed immediate.
- **Zero form:** writes the placed immediate with every other bit cleared.
- **Keep form:** merges the immediate into the old register value and leaves the other three lanes unchanged.

The unit flags two encodings as undefined and writes nothing for them:

- the reserved opcode;
- a 32-bit form that selects an upper lane.

Instructions outside the move-wide class are ignored. Choosing between the stack pointer and the zero register for index 31 is left to the register file.

Top module: `mwide_exec`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `wr_en` and `undef_op` are 0.
- R2: An accepted, legal instruction (`instr_valid` high and bits [28:23] equal to 100101) produces `wr_en` high on the clock edge that samples it. `wr_en` stays high for that one cycle only. The results are visible in the cycle after the instruction is presented.
- R3: Opcode bits [30:29] = 10 (zero form) writes the immediate from bits [20:5] into lane hw. All other bits are zero.
- R4: Opcode 00 (inverted form) writes the bitwise complement of the zero-form value.
- R5: Opcode 11 (keep form) writes `rd_old` with lane hw replaced by the immediate. The other lanes come from `rd_old` unchanged.
- R6: The hw field in bits [22:21] places the immediate at bit 16*hw. All four lanes, 0 to 3, are reachable in the 64-bit form.
- R7: Opcode 01 sets `undef_op` for one cycle and gives no write.
- R8: When bit 31 is 0 (32-bit form), every result, including the inverted form, has bits [63:32] equal to zero.
- R9: In the 32-bit form, hw = 2 or 3 sets `undef_op` and gives no write.
- R10: With `instr_valid` low, or with bits [28:23] not equal to 100101, both `wr_en` and `undef_op` stay 0 in the next cycle.
- R11: `wr_idx` equals bits [4:0] of the instruction. `wr_is32` equals the inverse of bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Decoded instruction word |
| rd_old | input | 64 | Current destination register value |
| wr_en | output | 1 | Register write enable, registered |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Value to write |
| wr_is32 | output | 1 | Result belongs to a 32-bit register form |
| undef_op | output | 1 | Undefined encoding seen, registered |

## Verification
The zero form is swept across every lane. An error in the hw-to-shift mapping then shows up as data in the wrong halfword.

The inverted and keep forms use old values whose lanes are all distinct. This separates a correct merge from one that clears, inverts or copies the wrong neighbouring lanes.

The 32-bit forms cover two cases:

- all three legal opcodes with an upper-half-filled `rd_old`, to expose a missing mask;
- hw = 2 and 3, to expose a missed undefined case.

Finally, the bench runs non-class words, idle cycles, the reserved opcode and back-to-back random instructions. These show that only legal class matches write, and that each writes for exactly one cycle.

// File: rtl/mwide_pkg.sv
package mwide_pkg;

   localparam int unsigned MW_INSTR_W = 32;
   localparam int unsigned MW_IDX_W   = 5;

   // field positions of the instruction word
   localparam int unsigned F_IDX_LO   = 0;
   localparam int unsigned F_IMM_LO   = 5;
   localparam int unsigned F_HW_LO    = 21;
   localparam int unsigned F_CLS_LO   = 23;
   localparam int unsigned F_OP_LO    = 29;
   localparam int unsigned F_SF_BIT   = 31;

   localparam logic [5:0] MW_CLASS    = 6'b100101;

   typedef enum logic [1:0] {
      MW_INV  = 2'b00,
      MW_RSV  = 2'b01,
      MW_ZERO = 2'b10,
      MW_KEEP = 2'b11
   } mw_op_e;

endpackage

// File: rtl/mwide_decode.sv
module mwide_decode
   import mwide_pkg::*;
#(
   parameter int unsigned IMM_W = 16,
   parameter int unsigned HW_W  = 2
) (
   input  logic [MW_INSTR_W-1:0] word,
   output logic                  is_class,
   output mw_op_e                op,
   output logic [HW_W-1:0]       hw,
   output logic [IMM_W-1:0]      imm,
   output logic [MW_IDX_W-1:0]   idx,
   output logic                  is64,
   output logic                  legal
);

   always_comb begin
      is_class = (word[F_CLS_LO +: 6] == MW_CLASS);
      op       = mw_op_e'(word[F_OP_LO +: 2]);
      hw       = word[F_HW_LO +: HW_W];
      imm      = word[F_IMM_LO +: IMM_W];
      idx      = word[F_IDX_LO +: MW_IDX_W];
      is64     = word[F_SF_BIT];
      // reserved opcode, or a 32-bit form that selects an upper lane
      legal    = (op != MW_RSV) && (is64 || !hw[HW_W-1]);
   end

endmodule

// File: rtl/mwide_lane_build.sv
module mwide_lane_build
   import mwide_pkg::*;
#(
   parameter int unsigned IMM_W = 16,
   parameter int unsigned LANES = 4,
   localparam int unsigned HW_W  = $clog2(LANES),
   localparam int unsigned DATA_W = IMM_W * LANES
) (
   input  mw_op_e             op,
   input  logic [HW_W-1:0]    hw,
   input  logic [IMM_W-1:0]   imm,
   input  logic               is64,
   input  logic [DATA_W-1:0]  old_val,
   output logic [DATA_W-1:0]  result
);

   localparam int unsigned NARROW_LANES = LANES / 2;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [HW_W-1:0] LANE_ID = g[HW_W-1:0];
      logic             sel;
      logic [IMM_W-1:0] lane_val;

      always_comb begin
         sel = (hw == LANE_ID);
         unique case (op)
            MW_INV:  lane_val = sel ? ~imm : {IMM_W{1'b1}};
            MW_ZERO: lane_val = sel ? imm  : '0;
            MW_KEEP: lane_val = sel ? imm  : old_val[g*IMM_W +: IMM_W];
            default: lane_val = '0;
         endcase
         // narrow form zero-extends into the upper half
         if (!is64 && (g >= NARROW_LANES))
            lane_val = '0;
      end

      assign result[g*IMM_W +: IMM_W] = lane_val;
   end

endmodule

// File: rtl/mwide_exec.sv
module mwide_exec
   import mwide_pkg::*;
#(
   parameter int unsigned IMM_W = 16,
   parameter int unsigned LANES = 4,
   localparam int unsigned HW_W   = $clog2(LANES),
   localparam int unsigned DATA_W = IMM_W * LANES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  instr_valid,
   input  logic [MW_INSTR_W-1:0] instr_word,
   input  logic [DATA_W-1:0]     rd_old,
   output logic                  wr_en,
   output logic [MW_IDX_W-1:0]   wr_idx,
   output logic [DATA_W-1:0]     wr_data,
   output logic                  wr_is32,
   output logic                  undef_op
);

   // the instruction fields are fixed: 16-bit immediate, 2-bit hw, 4 lanes
   if (IMM_W != 16 || LANES != 4) begin : g_bad_cfg
      $error("mwide_exec: field layout needs IMM_W=16 and LANES=4");
   end

   logic             dec_class;
   mw_op_e           dec_op;
   logic [HW_W-1:0]  dec_hw;
   logic [IMM_W-1:0] dec_imm;
   logic [MW_IDX_W-1:0] dec_idx;
   logic             dec_is64;
   logic             dec_legal;
   logic [DATA_W-1:0] lane_result;
   logic             accept;

   mwide_decode #(.IMM_W(IMM_W), .HW_W(HW_W)) u_dec (
      .word     (instr_word),
      .is_class (dec_class),
      .op       (dec_op),
      .hw       (dec_hw),
      .imm      (dec_imm),
      .idx      (dec_idx),
      .is64     (dec_is64),
      .legal    (dec_legal)
   );

   mwide_lane_build #(.IMM_W(IMM_W), .LANES(LANES)) u_build (
      .op      (dec_op),
      .hw      (dec_hw),
      .imm     (dec_imm),
      .is64    (dec_is64),
      .old_val (rd_old),
      .result  (lane_result)
   );

   assign accept = instr_valid && dec_class;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en    <= 1'b0;
         undef_op <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         wr_is32  <= 1'b0;
      end else begin
         wr_en    <= accept && dec_legal;
         undef_op <= accept && !dec_legal;
         if (accept && dec_legal) begin
            wr_idx  <= dec_idx;
            wr_data <= lane_result;
            wr_is32 <= !dec_is64;
         end
      end
   end

endmodule

// File: rtl/mwide_exec_chk.sv
module mwide_exec_chk
   import mwide_pkg::*;
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  instr_valid,
   input logic [MW_INSTR_W-1:0] instr_word,
   input logic [63:0]           rd_old,
   input logic                  wr_en,
   input logic [MW_IDX_W-1:0]   wr_idx,
   input logic [63:0]           wr_data,
   input logic                  wr_is32,
   input logic                  undef_op
);

   a_r7_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      undef_op |-> !wr_en);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(instr_valid) |-> (!wr_en && !undef_op));

   a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_is32) |-> (wr_data[63:32] == 32'h0));

   a_r11_index: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx == $past(instr_word[F_IDX_LO +: MW_IDX_W])));

   a_r11_width: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_is32 == !$past(instr_word[F_SF_BIT])));

   a_r5_keep_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(instr_word[F_OP_LO +: 2]) == 2'b11
             && $past(instr_word[F_HW_LO +: 2]) != 2'b00)
      |-> (wr_data[15:0] == $past(rd_old[15:0])));

   a_r4_inv_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(instr_word[F_OP_LO +: 2]) == 2'b00
             && $past(instr_word[F_HW_LO +: 2]) != 2'b00)
      |-> (wr_data[15:0] == 16'hFFFF));

   a_r3_zero_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(instr_word[F_OP_LO +: 2]) == 2'b10
             && $past(instr_word[F_HW_LO +: 2]) == 2'b00)
      |-> (wr_data[63:16] == 48'h0));

endmodule

bind mwide_exec mwide_exec_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_word  (instr_word),
   .rd_old      (rd_old),
   .wr_en       (wr_en),
   .wr_idx      (wr_idx),
   .wr_data     (wr_data),
   .wr_is32     (wr_is32),
   .undef_op    (undef_op)
);

// File: tb/mwide_exec_tb_top.sv
`timescale 1ns/1ps
module mwide_exec_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [63:0] rd_old = '0;
   logic        wr_en;
   logic [4:0]  wr_idx;
   logic [63:0] wr_data;
   logic        wr_is32;
   logic        undef_op;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   // expectation for the outputs seen after the next edge
   logic        e_en = 0, e_undef = 0, e_is32 = 0;
   logic [4:0]  e_idx = 0;
   logic [63:0] e_data = 0;
   string       e_tag = "R1";

   always #5 clk = ~clk;

   mwide_exec dut_i (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
      .instr_word(instr_word), .rd_old(rd_old), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data), .wr_is32(wr_is32),
      .undef_op(undef_op)
   );

   function automatic logic [31:0] mk(input bit sf, input bit [1:0] op,
                                      input bit [1:0] hw, input bit [15:0] imm,
                                      input bit [4:0] rd);
      return {sf, op, 6'b100101, hw, imm, rd};
   endfunction

   // behavioural reference
   task automatic model(input logic v, input logic [31:0] w, input logic [63:0] old);
      logic [63:0] placed, mask, res;
      int sh;
      e_en = 0; e_undef = 0;
      if (!v || w[28:23] != 6'b100101) return;
      sh = 16 * int'(w[22:21]);
      placed = 64'(w[20:5]) << sh;
      mask   = 64'hFFFF << sh;
      if (w[30:29] == 2'b01 || (!w[31] && w[22])) begin
         e_undef = 1;
         return;
      end
      case (w[30:29])
         2'b00:   res = ~placed;
         2'b10:   res = placed;
         default: res = (old & ~mask) | placed;
      endcase
      if (!w[31]) res = res & 64'h0000_0000_FFFF_FFFF;
      e_en = 1; e_data = res; e_idx = w[4:0]; e_is32 = !w[31];
   endtask

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      check(e_tag, "wr_en", 64'(wr_en), 64'(e_en));
      check(e_tag, "undef_op", 64'(undef_op), 64'(e_undef));
      if (e_en) begin
         check(e_tag, "wr_data", wr_data, e_data);
         check("R11", "wr_idx", 64'(wr_idx), 64'(e_idx));
         check("R11", "wr_is32", 64'(wr_is32), 64'(e_is32));
      end
   endtask

   task automatic step(input string tag, input logic v, input logic [31:0] w,
                       input logic [63:0] old);
      @(negedge clk);
      compare();
      instr_valid = v; instr_word = w; rd_old = old;
      model(v, w, old);
      e_tag = tag;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      e_tag = "R1";
      compare();
      rst_n = 1'b1;
      step("R1", 0, 32'h0, 64'h0);
      // R3 / R6: zero form in every lane
      for (int h = 0; h < 4; h++)
         step("R3", 1, mk(1, 2'b10, 2'(h), 16'hA5C3 + 16'(h), 5'(h + 1)), 64'hDEAD_BEEF_0123_4567);
      // R4: inverted form, all lanes
      for (int h = 0; h < 4; h++)
         step("R4", 1, mk(1, 2'b00, 2'(h), 16'h1234, 5'd7), 64'h0);
      // R5: keep form with distinct lanes
      for (int h = 0; h < 4; h++)
         step("R5", 1, mk(1, 2'b11, 2'(h), 16'hCAFE, 5'd31), 64'h1111_2222_3333_4444);
      // R8: 32-bit legal forms with upper-half-filled old value
      step("R8", 1, mk(0, 2'b00, 2'd0, 16'h00FF, 5'd3), 64'hFFFF_FFFF_FFFF_FFFF);
      step("R8", 1, mk(0, 2'b00, 2'd1, 16'h8001, 5'd4), 64'hFFFF_FFFF_0000_0000);
      step("R8", 1, mk(0, 2'b10, 2'd1, 16'hBEEF, 5'd5), 64'hFFFF_FFFF_FFFF_FFFF);
      step("R8", 1, mk(0, 2'b11, 2'd0, 16'h5A5A, 5'd6), 64'h9999_8888_7777_6666);
      step("R8", 1, mk(0, 2'b11, 2'd1, 16'h0000, 5'd6), 64'h9999_8888_7777_6666);
      // R9: 32-bit form selecting an upper lane
      step("R9", 1, mk(0, 2'b10, 2'd2, 16'h1111, 5'd8), 64'h0);
      step("R9", 1, mk(0, 2'b00, 2'd3, 16'h2222, 5'd9), 64'h0);
      // R7: reserved opcode
      step("R7", 1, mk(1, 2'b01, 2'd0, 16'h3333, 5'd10), 64'h0);
      step("R7", 1, mk(0, 2'b01, 2'd1, 16'h3333, 5'd10), 64'h0);
      // R10: not in class, or not valid
      step("R10", 1, mk(1, 2'b10, 2'd0, 16'h4444, 5'd11) ^ 32'h0080_0000, 64'h0);
      step("R10", 0, mk(1, 2'b10, 2'd0, 16'h4444, 5'd11), 64'h0);
      step("R10", 1, 32'h0000_0000, 64'h0);
      // R2: back-to-back then idle, one-cycle pulses
      step("R2", 1, mk(1, 2'b10, 2'd3, 16'hFFFF, 5'd1), 64'h0);
      step("R2", 1, mk(1, 2'b11, 2'd2, 16'h0001, 5'd2), 64'hAAAA_BBBB_CCCC_DDDD);
      step("R2", 0, 32'h0, 64'h0);
      step("R2", 0, 32'h0, 64'h0);
      // R6: random mix, mostly in class
      for (int k = 0; k < 200; k++) begin
         logic [31:0] w;
         w = $urandom;
         if (k % 8 != 0) w[28:23] = 6'b100101;
         step("R6", (k % 5) != 0, w, {$urandom, $urandom});
      end
      step("R2", 0, 32'h0, 64'h0);
      @(negedge clk);
      compare();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL R2 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule